// File: doc/BRIEF.md
# AES-128 Block Engine with Byte Register Window

This block encrypts and decrypts 128-bit blocks with the standard AES-128 cipher. A host reaches it only through a small window of byte registers. The host first loads a key, picks the chaining mode and the direction, and writes a 16-byte block. It then sets a start bit and, once the engine is idle again, reads the 16-byte result from the same addresses it wrote the input to. The cipher core is iterative and performs one round per clock. It expands round keys on the fly from a stored copy of the user key, and that copy is never changed, so any number of blocks can be processed without loading the key again.

In electronic code book mode both directions are available. In cipher block chaining mode only encryption is offered. Every byte written to the data window in that mode is XORed into the byte already held there, so the previous ciphertext (or an initialisation vector the host loaded in ECB mode) chains into the next block without extra host work. A fast-access write returns, on the read data port, the byte that the same address held before the write. This lets the host stream the next input while it collects the previous output.

Top module: `aes_reg_engine`

## Requirements
- R1: After reset, the status byte (0x82), the control byte (0x83), its mirror (0x94) and every data byte (0x84..0x93) read as 0x00.
- R2: With the control mode field (bits 3:2) at 00 and the decrypt bit (bit 1) clear, a start produces the AES-128 ciphertext of the data window. Byte 0x84 is the first (most significant) block byte, and the result matches the published AES-128 test vectors.
- R3: With mode 00 and the decrypt bit set, a start replaces the data window with the AES-128 plaintext of the ciphertext it held.
- R4: With mode 01, data window writes load the key register instead of the data bytes. No operation alters the key, so later operations reuse it unchanged.
- R5: With mode 10, a data write stores the written byte XORed with the byte held at that address. Starting an encryption there gives CBC chaining from the initialisation vector or the previous ciphertext.
- R6: A fast-access write to a data address returns, on the read data port one cycle later, the byte held at that address before the write.
- R7: The status byte has done in bit 0, busy in bit 1 and error in bit 7. Done clears on a start and sets when the result is written. Done and busy are never set together.
- R8: A start with decrypt in mode 10, or with mode 01 or 11, sets the error bit and starts nothing. The data window is left unchanged. The next accepted start clears the error bit.
- R9: Bit 0 of the control byte is a start strobe that always reads back 0. Bits 7:1 read back as written. Address 0x94 reads and writes the same register as 0x83.
- R10: While busy, writes to the data window and to the control byte are ignored.
- R11: Busy stays high for exactly 10 cycles for an encryption and 20 cycles for a decryption: 10 cycles of forward key expansion followed by 10 inverse rounds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Register access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_fast | input | 1 | Write also returns the old data byte (fast access) |
| acc_addr | input | 8 | Byte address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid the cycle after a read or fast write |
| busy | output | 1 | Operation in progress |

## Verification
Two functions can fall in the same cycle: a fast-access write that loads a new input byte, and the read-out of the previous result byte at that address. The same cycle also carries the CBC XOR into that byte. The bench streams a second CBC block, and later an ECB block, with fast writes. Each returned byte is scored against the previous ciphertext, and the next result is scored against the published vector, which is only correct if the XOR used the old byte. A second overlap is a start together with writes issued while busy. The bench writes into the data window and the control byte during a run and checks that the result and the read-back control value are unaffected.

// File: rtl/aes_eng_pkg.sv
package aes_eng_pkg;

    localparam int BLK_BYTES  = 16;
    localparam int NUM_ROUNDS = 10;
    localparam int BLK_BITS   = 8 * BLK_BYTES;

    typedef enum logic [1:0] {
        MD_ECB = 2'd0,
        MD_KEY = 2'd1,
        MD_CBC = 2'd2,
        MD_RSV = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_KEXP = 2'd1,
        PH_ENC  = 2'd2,
        PH_DEC  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [BLK_BITS-1:0] key;
        logic [BLK_BITS-1:0] dat;
        logic [BLK_BITS-1:0] st;
        logic [BLK_BITS-1:0] rk;
        logic [7:0]          ctrl;
        logic                done;
        logic                err;
        phase_e              ph;
        logic [3:0]          rnd;
        logic [7:0]          rdata;
    } regs_t;

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        logic [7:0] p;
        r = 8'h00;
        p = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ p;
            p = xtime(p);
        end
        return r;
    endfunction

    // multiplicative inverse as a^254, zero maps to zero
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] p;
        r = 8'h01;
        p = a;
        for (int i = 1; i < 8; i++) begin
            p = gmul(p, p);
            r = gmul(r, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] inv_sbox(input logic [7:0] s);
        return gf_inv(rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05);
    endfunction

    function automatic logic [7:0] rcon(input logic [3:0] r);
        logic [7:0] c;
        c = 8'h01;
        for (int i = 1; i < NUM_ROUNDS; i++) begin
            if (i < int'(r)) c = xtime(c);
        end
        return c;
    endfunction

    function automatic logic [31:0] sub_rot_word(input logic [31:0] w);
        logic [31:0] t;
        t = {w[23:0], w[31:24]};
        return {sbox(t[31:24]), sbox(t[23:16]), sbox(t[15:8]), sbox(t[7:0])};
    endfunction

    function automatic logic [31:0] mix_col(input logic [31:0] c);
        logic [7:0] a0, a1, a2, a3;
        {a0, a1, a2, a3} = c;
        return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
                a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
                a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
                xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
    endfunction

    function automatic logic [31:0] inv_mix_col(input logic [31:0] c);
        logic [7:0] a0, a1, a2, a3;
        {a0, a1, a2, a3} = c;
        return {gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09),
                gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d),
                gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b),
                gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e)};
    endfunction

endpackage

// File: rtl/aes_key_step.sv
module aes_key_step
    import aes_eng_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [BLK_BITS-1:0] key_in,
    input  logic [3:0]          rnd,
    output logic [BLK_BITS-1:0] key_out
);
    logic [31:0] w0, w1, w2, w3;
    assign {w0, w1, w2, w3} = key_in;

    generate
        if (INVERSE) begin : g_inv
            // recover round rnd-1 key from round rnd key
            logic [31:0] p1, p2, p3;
            assign p3 = w3 ^ w2;
            assign p2 = w2 ^ w1;
            assign p1 = w1 ^ w0;
            assign key_out = {w0 ^ sub_rot_word(p3) ^ {rcon(rnd), 24'h0}, p1, p2, p3};
        end else begin : g_fwd
            // derive round rnd key from round rnd-1 key
            logic [31:0] n0, n1, n2, n3;
            assign n0 = w0 ^ sub_rot_word(w3) ^ {rcon(rnd), 24'h0};
            assign n1 = w1 ^ n0;
            assign n2 = w2 ^ n1;
            assign n3 = w3 ^ n2;
            assign key_out = {n0, n1, n2, n3};
        end
    endgenerate
endmodule

// File: rtl/aes_round.sv
module aes_round
    import aes_eng_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [BLK_BITS-1:0] st_in,
    input  logic [BLK_BITS-1:0] rkey,
    input  logic                last,
    output logic [BLK_BITS-1:0] st_out
);
    localparam int NCOL = BLK_BYTES / 4;

    logic [BLK_BITS-1:0] stage_a;
    logic [BLK_BITS-1:0] stage_b;
    logic [BLK_BITS-1:0] stage_c;

    generate
        if (INVERSE) begin : g_inv
            always_comb begin
                for (int c = 0; c < NCOL; c++) begin
                    for (int r = 0; r < 4; r++) begin
                        stage_a[BLK_BITS-1-8*(4*c+r) -: 8] =
                            st_in[BLK_BITS-1-8*(4*((c-r+4)%4)+r) -: 8];
                    end
                end
                for (int i = 0; i < BLK_BYTES; i++) begin
                    stage_b[BLK_BITS-1-8*i -: 8] = inv_sbox(stage_a[BLK_BITS-1-8*i -: 8]);
                end
                stage_b = stage_b ^ rkey;
                for (int c = 0; c < NCOL; c++) begin
                    stage_c[BLK_BITS-1-32*c -: 32] = inv_mix_col(stage_b[BLK_BITS-1-32*c -: 32]);
                end
                st_out = last ? stage_b : stage_c;
            end
        end else begin : g_fwd
            always_comb begin
                for (int i = 0; i < BLK_BYTES; i++) begin
                    stage_a[BLK_BITS-1-8*i -: 8] = sbox(st_in[BLK_BITS-1-8*i -: 8]);
                end
                for (int c = 0; c < NCOL; c++) begin
                    for (int r = 0; r < 4; r++) begin
                        stage_b[BLK_BITS-1-8*(4*c+r) -: 8] =
                            stage_a[BLK_BITS-1-8*(4*((c+r)%4)+r) -: 8];
                    end
                end
                for (int c = 0; c < NCOL; c++) begin
                    stage_c[BLK_BITS-1-32*c -: 32] = mix_col(stage_b[BLK_BITS-1-32*c -: 32]);
                end
                st_out = (last ? stage_b : stage_c) ^ rkey;
            end
        end
    endgenerate
endmodule

// File: rtl/aes_reg_engine.sv
module aes_reg_engine
    import aes_eng_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'h82
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_en,
    input  logic       acc_we,
    input  logic       acc_fast,
    input  logic [7:0] acc_addr,
    input  logic [7:0] acc_wdata,
    output logic [7:0] acc_rdata,
    output logic       busy
);
    localparam logic [7:0] STAT_ADDR = BASE_ADDR;
    localparam logic [7:0] CTRL_ADDR = BASE_ADDR + 8'd1;
    localparam logic [7:0] DATA_LO   = BASE_ADDR + 8'd2;
    localparam logic [7:0] DATA_HI   = DATA_LO + 8'(BLK_BYTES - 1);
    localparam logic [7:0] MIRR_ADDR = DATA_HI + 8'd1;
    localparam logic [3:0] LAST_RND  = 4'(NUM_ROUNDS);

    regs_t r_q, r_d;

    logic [BLK_BITS-1:0] key_fwd, key_inv, enc_out, dec_out;
    logic                in_win, is_ctrl;
    logic [3:0]          idx;
    logic [7:0]          rd_byte;
    mode_e               mode_q, mode_new;
    logic                start_ok;

    aes_key_step #(.INVERSE(1'b0)) u_kfwd (
        .key_in (r_q.rk), .rnd(r_q.rnd), .key_out(key_fwd));
    aes_key_step #(.INVERSE(1'b1)) u_kinv (
        .key_in (r_q.rk), .rnd(r_q.rnd), .key_out(key_inv));
    aes_round #(.INVERSE(1'b0)) u_enc (
        .st_in(r_q.st), .rkey(key_fwd), .last(r_q.rnd == LAST_RND), .st_out(enc_out));
    aes_round #(.INVERSE(1'b1)) u_dec (
        .st_in(r_q.st), .rkey(key_inv), .last(r_q.rnd == 4'd1), .st_out(dec_out));

    assign busy     = (r_q.ph != PH_IDLE);
    assign in_win   = (acc_addr >= DATA_LO) && (acc_addr <= DATA_HI);
    assign is_ctrl  = (acc_addr == CTRL_ADDR) || (acc_addr == MIRR_ADDR);
    assign idx      = 4'(acc_addr - DATA_LO);
    assign mode_q   = mode_e'(r_q.ctrl[3:2]);
    assign mode_new = mode_e'(acc_wdata[3:2]);
    assign start_ok = (mode_new == MD_ECB) || (mode_new == MD_CBC && !acc_wdata[1]);

    always_comb begin
        if (in_win)                      rd_byte = r_q.dat[8*(15-idx) +: 8];
        else if (is_ctrl)                rd_byte = r_q.ctrl;
        else if (acc_addr == STAT_ADDR)  rd_byte = {r_q.err, 5'b0, busy, r_q.done};
        else                             rd_byte = 8'h00;
    end

    always_comb begin
        r_d = r_q;

        unique case (r_q.ph)
            PH_ENC: begin
                r_d.rk  = key_fwd;
                r_d.st  = enc_out;
                r_d.rnd = r_q.rnd + 4'd1;
                if (r_q.rnd == LAST_RND) begin
                    r_d.dat  = enc_out;
                    r_d.ph   = PH_IDLE;
                    r_d.done = 1'b1;
                end
            end
            PH_KEXP: begin
                r_d.rk = key_fwd;
                if (r_q.rnd == LAST_RND) begin
                    r_d.st = r_q.dat ^ key_fwd;
                    r_d.ph = PH_DEC;
                end else begin
                    r_d.rnd = r_q.rnd + 4'd1;
                end
            end
            PH_DEC: begin
                r_d.rk  = key_inv;
                r_d.st  = dec_out;
                r_d.rnd = r_q.rnd - 4'd1;
                if (r_q.rnd == 4'd1) begin
                    r_d.dat  = dec_out;
                    r_d.ph   = PH_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: ;
        endcase

        if (acc_en && (!acc_we || (acc_fast && in_win))) begin
            r_d.rdata = rd_byte;
        end

        if (acc_en && acc_we && !busy) begin
            if (in_win) begin
                unique case (mode_q)
                    MD_KEY:  r_d.key[8*(15-idx) +: 8] = acc_wdata;
                    MD_CBC:  r_d.dat[8*(15-idx) +: 8] = r_q.dat[8*(15-idx) +: 8] ^ acc_wdata;
                    default: r_d.dat[8*(15-idx) +: 8] = acc_wdata;
                endcase
            end else if (is_ctrl) begin
                r_d.ctrl = {acc_wdata[7:1], 1'b0};
                if (acc_wdata[0]) begin
                    r_d.done = 1'b0;
                    r_d.err  = !start_ok;
                    if (start_ok) begin
                        r_d.rk  = r_q.key;
                        r_d.rnd = 4'd1;
                        if (acc_wdata[1]) begin
                            r_d.ph = PH_KEXP;
                        end else begin
                            r_d.ph = PH_ENC;
                            r_d.st = r_q.dat ^ r_q.key;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign acc_rdata = r_q.rdata;

    // observation points for the bound checker
    logic [BLK_BITS-1:0] key_w, dat_w;
    logic                done_w, err_w;
    assign key_w  = r_q.key;
    assign dat_w  = r_q.dat;
    assign done_w = r_q.done;
    assign err_w  = r_q.err;
endmodule

// File: rtl/aes_engine_chk.sv
module aes_engine_chk
    import aes_eng_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                done,
    input logic                err,
    input logic [BLK_BITS-1:0] key,
    input logic [BLK_BITS-1:0] dat
);
    localparam int ENC_LEN = NUM_ROUNDS;
    localparam int DEC_LEN = 2 * NUM_ROUNDS;

    logic [5:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 6'd1;
        else           run_len <= '0;
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R7

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done); // R7

    AST_KEY_HELD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(key)); // R4

    AST_DATA_FROZEN_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(dat)); // R10

    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy); // R8

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 6'(ENC_LEN) || run_len == 6'(DEC_LEN))); // R11

endmodule

bind aes_reg_engine aes_engine_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .busy (busy),
    .done (done_w),
    .err  (err_w),
    .key  (key_w),
    .dat  (dat_w)
);

// File: tb/tb_aes_reg_engine.sv
`timescale 1ns/1ps
module tb_aes_reg_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_we = 1'b0;
    logic       acc_fast = 1'b0;
    logic [7:0] acc_addr = 8'h00;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] acc_rdata;
    logic       busy;

    aes_reg_engine dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_fast(acc_fast), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .busy(busy));

    always #2.5 clk = ~clk;

    localparam logic [7:0] A_STAT = 8'h82;
    localparam logic [7:0] A_CTRL = 8'h83;
    localparam logic [7:0] A_DAT  = 8'h84;
    localparam logic [7:0] A_MIRR = 8'h94;

    localparam logic [127:0] KEY_A = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] PT_A  = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] CT_A  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam logic [127:0] KEY_B = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] PT_B  = 128'h3243f6a8885a308d313198a2e0370734;
    localparam logic [127:0] CT_B  = 128'h3925841d02dc09fbdc118597196a0b32;
    localparam logic [127:0] IV_C  = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] P1    = 128'h6bc1bee22e409f96e93d7e117393172a;
    localparam logic [127:0] P2    = 128'hae2d8a571e03ac9c9eb76fac45af8e51;
    localparam logic [127:0] C1    = 128'h7649abac8119b246cee98e9b12e9197d;
    localparam logic [127:0] C2    = 128'h5086cb9b507219ee95db113a917678b2;
    localparam logic [127:0] E1    = 128'h3ad77bb40d7a3660a89ecaf32466ef97;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    ended = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rsp_due = 1'b0;

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: a response is due one cycle after a read or a fast data write
    always @(posedge clk)
        rsp_due <= acc_en && (!acc_we || (acc_fast && acc_addr >= A_DAT && acc_addr < A_MIRR));

    always @(negedge clk) begin
        if (rsp_due) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected response rdata=%02h expected=none", acc_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (acc_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s rdata=%02h expected=%02h", t, acc_rdata, e);
                end
            end
        end
    end

    task automatic check_int(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic fast, input logic [7:0] a, input logic [7:0] d);
        acc_en = 1'b1; acc_we = we; acc_fast = fast; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0; acc_fast = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        access(1'b1, 1'b0, a, d);
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        access(1'b0, 1'b0, a, 8'h00);
    endtask

    task automatic wr_block(input logic [127:0] blk);
        for (int i = 0; i < 16; i++) wr(8'(A_DAT + i), blk[127-8*i -: 8]);
    endtask

    task automatic rd_block(input logic [127:0] blk, input string tag);
        for (int i = 0; i < 16; i++) rd_exp(8'(A_DAT + i), blk[127-8*i -: 8], tag);
    endtask

    task automatic fast_block(input logic [127:0] din, input logic [127:0] old, input string tag);
        for (int i = 0; i < 16; i++) begin
            exp_q.push_back(old[127-8*i -: 8]);
            tag_q.push_back(tag);
            access(1'b1, 1'b1, 8'(A_DAT + i), din[127-8*i -: 8]);
        end
    endtask

    task automatic run(input logic [7:0] ctrl, output int cyc);
        wr(A_CTRL, ctrl);
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int cyc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd_exp(A_STAT, 8'h00, "R1 status");
        rd_exp(A_CTRL, 8'h00, "R1 ctrl");
        rd_exp(A_MIRR, 8'h00, "R1 mirror");
        rd_exp(A_DAT, 8'h00, "R1 data first");
        rd_exp(8'h93, 8'h00, "R1 data last");

        // R4 key load via mode 01
        wr(A_CTRL, 8'h04);
        rd_exp(A_CTRL, 8'h04, "R9 ctrl readback");
        wr_block(KEY_A);
        rd_exp(A_DAT, 8'h00, "R4 key write bypasses data");

        // R2 ECB encrypt, R11 latency
        wr(A_CTRL, 8'h00);
        wr_block(PT_A);
        run(8'h01, cyc);
        check_int(cyc, 10, "R11 encrypt busy cycles");
        rd_exp(A_STAT, 8'h01, "R7 done after encrypt");
        rd_block(CT_A, "R2 ECB encrypt vector A");

        // R3 ECB decrypt with the kept key (R4)
        run(8'h03, cyc);
        check_int(cyc, 20, "R11 decrypt busy cycles");
        rd_block(PT_A, "R3 ECB decrypt vector A with kept key R4");
        rd_exp(A_CTRL, 8'h02, "R9 start bit reads zero");
        rd_exp(A_MIRR, 8'h02, "R9 mirror matches");

        // R10 writes while busy ignored
        wr(A_CTRL, 8'h01);
        wr(A_DAT, 8'hff);
        wr(A_MIRR, 8'h08);
        rd_exp(A_STAT, 8'h02, "R7 busy set done cleared");
        rd_exp(A_CTRL, 8'h00, "R10 ctrl write ignored");
        while (busy) @(negedge clk);
        rd_block(CT_A, "R10 data write ignored");

        // R8 illegal starts
        wr(A_CTRL, 8'h0b);
        check_int(int'(busy), 0, "R8 no run on cbc decrypt");
        rd_exp(A_STAT, 8'h80, "R8 error flag");
        rd_exp(A_DAT, 8'h69, "R8 data untouched");
        rd_exp(A_CTRL, 8'h0a, "R9 fields kept");
        wr(A_CTRL, 8'h05);
        rd_exp(A_STAT, 8'h80, "R8 error on key mode start");

        // second key, R2 vector B
        wr_block(KEY_B);
        wr(A_CTRL, 8'h00);
        wr_block(PT_B);
        run(8'h01, cyc);
        rd_exp(A_STAT, 8'h01, "R8 error cleared by good start");
        rd_block(CT_B, "R2 ECB encrypt vector B");

        // R5 CBC chaining
        wr_block(IV_C);
        wr(A_CTRL, 8'h08);
        wr_block(P1);
        run(8'h09, cyc);
        check_int(cyc, 10, "R11 cbc busy cycles");
        rd_block(C1, "R5 CBC block 1");
        fast_block(P2, C1, "R6 fast write returns old byte");
        run(8'h09, cyc);
        rd_block(C2, "R5 CBC block 2");

        // R6 fast access in ECB
        wr(A_CTRL, 8'h00);
        fast_block(P1, C2, "R6 fast write in ECB");
        run(8'h01, cyc);
        rd_block(E1, "R2 ECB encrypt vector C");
        run(8'h03, cyc);
        rd_block(P1, "R3 ECB decrypt vector C");

        repeat (3) @(negedge clk);
        check_int(exp_q.size(), 0, "R6 all responses seen");
        finish_run();
    end

endmodule